// File: doc/BRIEF.md
# Refuse-and-Retry Port Front End

This block sits between several requesters and one shared target that serves a single request at a time. Each requester raises a request. In the same cycle the block either takes it and forwards it to the target, tagged with the requester's index, or turns it down. A requester that was turned down is recorded as owed a retry. Later, when the target is idle and that requester has nothing left undelivered, the block sends it a one-cycle retry pulse so it can try again.

Responses from the target carry a port index and are routed to that requester in the same cycle. A requester may refuse a response. The response is then kept in a one-entry holding register for that port. When the requester signals that it is ready again, the held response is offered once more on the following cycle, and it may be refused again. The memory side reuses the same hold-and-resend stage for outgoing requests, driven by the memory's accept and retry signals. An attempt to push into a holding register that is already full is reported as an overflow error.

Top module: `retry_port_front`

## Requirements
- R1: A request is accepted only when its valid is high, the target is not busy, and the port holds no response and owes no retry. Among eligible ports only the lowest index is accepted. The accepted request appears on the target side in the same cycle with the port index and payload.
- R2: A request that is not accepted sets the port's owed-retry flag. This covers a busy target, a held response, an owed retry, or losing to a lower index.
- R3: A retry pulse goes to a port only while it owes a retry, holds no response and the target is not busy. Issuing the pulse clears the owed flag.
- R4: When several ports are eligible for a retry, only the lowest index gets a pulse in a given cycle. The others follow in later cycles.
- R5: A target response is presented on the port named by its tag in the same cycle. If that port's response accept is low, the response is kept in the port's holding register.
- R6: A response-retry input on a port with a held response makes the held data appear on the next cycle. If it is refused again, it stays held.
- R7: Once a resent response is accepted, an owed retry for that port is issued on the following cycle, provided the target is not busy.
- R8: A response or memory send that arrives while the matching holding register is full raises the overflow error in that cycle. The held contents are kept.
- R9: On the memory side, a send that is not accepted is held and the hold-full output is raised. The memory retry input makes the held request reappear on the next cycle. Acceptance empties the register.
- R10: Reset empties every holding register and clears every owed flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | NUM_PORTS | Request present, one bit per port |
| req_data | input | NUM_PORTS*DATA_W | Request payloads, port p at bits p*DATA_W |
| req_accept | output | NUM_PORTS | Request taken this cycle |
| retry | output | NUM_PORTS | One-cycle retry notification |
| resp_valid | output | NUM_PORTS | Response offered to port |
| resp_data | output | NUM_PORTS*DATA_W | Response payloads |
| resp_accept | input | NUM_PORTS | Requester takes offered response |
| resp_retry | input | NUM_PORTS | Requester ready for a held response |
| tgt_busy | input | 1 | Shared target is serving a request |
| tgt_req_valid | output | 1 | Request forwarded to target |
| tgt_req_port | output | PORT_W | Index of forwarded request |
| tgt_req_data | output | DATA_W | Forwarded payload |
| tgt_resp_valid | input | 1 | Target response present |
| tgt_resp_port | input | PORT_W | Port the response belongs to |
| tgt_resp_data | input | DATA_W | Response payload |
| mem_send_valid | input | 1 | Target wants to send to memory |
| mem_send_data | input | MEM_W | Outgoing memory payload |
| mem_hold_full | output | 1 | Memory-side holding register occupied |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_data | output | MEM_W | Payload offered to memory |
| mem_req_accept | input | 1 | Memory takes the offered request |
| mem_retry | input | 1 | Memory ready for a held request |
| overflow_err | output | 1 | Send into a full holding register |

## Verification
The bench builds the block with three ports and 8-bit payloads on both sides. Three ports is the smallest count at which two ports can owe retries while a third holds a response, so the priority order of R4 and the interaction between holding and retrying can both be seen. The 8-bit payloads make it possible to tell routed, held and resent data apart, and so to check that a held value survives an overflow attempt.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
   localparam int MAX_PORTS = 32;
   typedef enum logic [0:0] {HOLD_EMPTY = 1'b0, HOLD_FULL = 1'b1} hold_state_e;
endpackage

// File: rtl/rpf_pick_lowest.sv
module rpf_pick_lowest #(
   parameter int W = 4,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  cand,
   output logic [W-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   assign gnt = cand & (~cand + W'(1));
   assign any = |cand;

   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (cand[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/rpf_hold_resend.sv
module rpf_hold_resend
   import rpf_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          send_valid,
   input  logic [DW-1:0] send_data,
   input  logic          out_accept,
   input  logic          retry_in,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          full,
   output logic          overflow
);
   hold_state_e   state_q;
   logic          resend_q;
   logic [DW-1:0] data_q;

   assign full      = (state_q == HOLD_FULL);
   assign out_valid = send_valid | resend_q;
   assign out_data  = full ? data_q : send_data;
   assign overflow  = send_valid & full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= HOLD_EMPTY;
         resend_q <= 1'b0;
         data_q   <= '0;
      end else begin
         resend_q <= retry_in & full & ~resend_q;
         if (resend_q) begin
            if (out_accept) state_q <= HOLD_EMPTY;
         end else if (send_valid && !full && !out_accept) begin
            state_q <= HOLD_FULL;
            data_q  <= send_data;
         end
      end
   end

   // R6: a ready indication on a full register brings the data back next cycle
   assert_resend_after_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_in && full && !resend_q) |=> (out_valid && out_data == $past(data_q)));
   // R5: held data never disappears without being offered and taken
   assert_no_silent_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !(out_valid && out_accept)) |=> full);
   // R8: an overflow attempt leaves the held payload untouched
   assert_overflow_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> (data_q == $past(data_q)));
endmodule

// File: rtl/retry_port_front.sv
module retry_port_front
   import rpf_pkg::*;
#(
   parameter int NUM_PORTS = 3,
   parameter int DATA_W    = 8,
   parameter int MEM_W     = 8,
   localparam int PORT_W   = $clog2(NUM_PORTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        req_valid,
   input  logic [NUM_PORTS*DATA_W-1:0] req_data,
   output logic [NUM_PORTS-1:0]        req_accept,
   output logic [NUM_PORTS-1:0]        retry,
   output logic [NUM_PORTS-1:0]        resp_valid,
   output logic [NUM_PORTS*DATA_W-1:0] resp_data,
   input  logic [NUM_PORTS-1:0]        resp_accept,
   input  logic [NUM_PORTS-1:0]        resp_retry,
   input  logic                        tgt_busy,
   output logic                        tgt_req_valid,
   output logic [PORT_W-1:0]           tgt_req_port,
   output logic [DATA_W-1:0]           tgt_req_data,
   input  logic                        tgt_resp_valid,
   input  logic [PORT_W-1:0]           tgt_resp_port,
   input  logic [DATA_W-1:0]           tgt_resp_data,
   input  logic                        mem_send_valid,
   input  logic [MEM_W-1:0]            mem_send_data,
   output logic                        mem_hold_full,
   output logic                        mem_req_valid,
   output logic [MEM_W-1:0]            mem_req_data,
   input  logic                        mem_req_accept,
   input  logic                        mem_retry,
   output logic                        overflow_err
);
   if (NUM_PORTS < 2 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("retry_port_front: NUM_PORTS out of range");
   end
   if (DATA_W < 1 || MEM_W < 1) begin : g_bad_width
      $error("retry_port_front: payload widths must be positive");
   end

   logic [NUM_PORTS-1:0] owed_q;
   logic [NUM_PORTS-1:0] held;
   logic [NUM_PORTS-1:0] resp_ovf;
   logic [NUM_PORTS-1:0] acc_cand;
   logic [NUM_PORTS-1:0] rty_cand;
   logic [NUM_PORTS-1:0] refused;
   logic [PORT_W-1:0]    acc_idx;
   logic [PORT_W-1:0]    rty_idx;
   logic                 acc_any;
   logic                 rty_any;
   logic                 mem_ovf;

   // request side: one forward per cycle, lowest eligible index wins
   assign acc_cand = req_valid & ~held & ~owed_q & {NUM_PORTS{~tgt_busy}};

   rpf_pick_lowest #(.W(NUM_PORTS)) i_acc_pick (
      .cand(acc_cand), .gnt(req_accept), .idx(acc_idx), .any(acc_any));

   assign tgt_req_valid = acc_any;
   assign tgt_req_port  = acc_idx;
   assign tgt_req_data  = req_data[acc_idx*DATA_W +: DATA_W];
   assign refused       = req_valid & ~req_accept;

   // retry side: owed, nothing held, target free
   assign rty_cand = owed_q & ~held & {NUM_PORTS{~tgt_busy}};

   rpf_pick_lowest #(.W(NUM_PORTS)) i_rty_pick (
      .cand(rty_cand), .gnt(retry), .idx(rty_idx), .any(rty_any));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owed_q <= '0;
      else        owed_q <= (owed_q & ~retry) | refused;
   end

   // per-port response holding
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic route;
      assign route = tgt_resp_valid && (tgt_resp_port == PORT_W'(p));

      rpf_hold_resend #(.DW(DATA_W)) i_resp_hold (
         .clk        (clk),
         .rst_n      (rst_n),
         .send_valid (route),
         .send_data  (tgt_resp_data),
         .out_accept (resp_accept[p]),
         .retry_in   (resp_retry[p]),
         .out_valid  (resp_valid[p]),
         .out_data   (resp_data[p*DATA_W +: DATA_W]),
         .full       (held[p]),
         .overflow   (resp_ovf[p]));
   end

   // memory side reuses the same stage
   rpf_hold_resend #(.DW(MEM_W)) i_mem_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .send_valid (mem_send_valid),
      .send_data  (mem_send_data),
      .out_accept (mem_req_accept),
      .retry_in   (mem_retry),
      .out_valid  (mem_req_valid),
      .out_data   (mem_req_data),
      .full       (mem_hold_full),
      .overflow   (mem_ovf));

   assign overflow_err = (|resp_ovf) | mem_ovf;

   // R1: nothing is forwarded into a busy target, and at most one port per cycle
   assert_accept_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req_valid |-> (!tgt_busy && $onehot(req_accept)));
   // R2: every refused port owes a retry on the next cycle
   assert_refuse_owes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|refused) |=> ((owed_q & $past(refused)) == $past(refused)));
   // R3: no retry toward a port with a held response or while busy
   assert_retry_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rty_any |-> (!tgt_busy && (retry & held) == '0));
   // R4: a single retry pulse per cycle
   assert_retry_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(retry));
endmodule

// File: tb/test_retry_port_front.sv
module test_retry_port_front;
   localparam int N  = 3;
   localparam int DW = 8;
   localparam int MW = 8;
   localparam int PW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [N*DW-1:0] req_data = '0;
   logic [N-1:0]    req_accept, retry, resp_valid;
   logic [N*DW-1:0] resp_data;
   logic [N-1:0]    resp_accept = '0, resp_retry = '0;
   logic            tgt_busy = 1'b0;
   logic            tgt_req_valid;
   logic [PW-1:0]   tgt_req_port;
   logic [DW-1:0]   tgt_req_data;
   logic            tgt_resp_valid = 1'b0;
   logic [PW-1:0]   tgt_resp_port = '0;
   logic [DW-1:0]   tgt_resp_data = '0;
   logic            mem_send_valid = 1'b0;
   logic [MW-1:0]   mem_send_data = '0;
   logic            mem_hold_full, mem_req_valid;
   logic [MW-1:0]   mem_req_data;
   logic            mem_req_accept = 1'b0, mem_retry = 1'b0;
   logic            overflow_err;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   retry_port_front #(.NUM_PORTS(N), .DATA_W(DW), .MEM_W(MW)) i_retry_port_front (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_data(req_data), .req_accept(req_accept),
      .retry(retry), .resp_valid(resp_valid), .resp_data(resp_data),
      .resp_accept(resp_accept), .resp_retry(resp_retry),
      .tgt_busy(tgt_busy), .tgt_req_valid(tgt_req_valid),
      .tgt_req_port(tgt_req_port), .tgt_req_data(tgt_req_data),
      .tgt_resp_valid(tgt_resp_valid), .tgt_resp_port(tgt_resp_port),
      .tgt_resp_data(tgt_resp_data),
      .mem_send_valid(mem_send_valid), .mem_send_data(mem_send_data),
      .mem_hold_full(mem_hold_full), .mem_req_valid(mem_req_valid),
      .mem_req_data(mem_req_data), .mem_req_accept(mem_req_accept),
      .mem_retry(mem_retry), .overflow_err(overflow_err));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic idle_inputs();
      req_valid = '0; resp_accept = '0; resp_retry = '0; tgt_busy = 1'b0;
      tgt_resp_valid = 1'b0; tgt_resp_port = '0; tgt_resp_data = '0;
      mem_send_valid = 1'b0; mem_req_accept = 1'b0; mem_retry = 1'b0;
   endtask

   // row: req_valid, resp_accept, resp_retry, busy, resp_v, resp_port | accept, retry, resp_valid
   localparam int RW = 22;
   localparam logic [RW-1:0] TBL [0:15] = '{
      {3'b001, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 3'b001, 3'b000, 3'b000}, // R1
      {3'b110, 3'b000, 3'b000, 1'b1, 1'b0, 2'd0, 3'b000, 3'b000, 3'b000}, // R2 busy
      {3'b000, 3'b000, 3'b000, 1'b1, 1'b0, 2'd0, 3'b000, 3'b000, 3'b000}, // R3 busy blocks
      {3'b000, 3'b001, 3'b000, 1'b0, 1'b1, 2'd0, 3'b000, 3'b010, 3'b001}, // R4 R5
      {3'b000, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 3'b000, 3'b100, 3'b000}, // R4
      {3'b010, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 3'b010, 3'b000, 3'b000}, // R1
      {3'b100, 3'b000, 3'b000, 1'b1, 1'b1, 2'd1, 3'b000, 3'b000, 3'b010}, // R5 held
      {3'b010, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 3'b000, 3'b100, 3'b000}, // R2 held
      {3'b010, 3'b000, 3'b010, 1'b0, 1'b0, 2'd0, 3'b000, 3'b000, 3'b000}, // R2 owed
      {3'b000, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 3'b000, 3'b000, 3'b010}, // R6 fails
      {3'b000, 3'b000, 3'b010, 1'b0, 1'b0, 2'd0, 3'b000, 3'b000, 3'b000}, // R6
      {3'b000, 3'b010, 3'b000, 1'b0, 1'b0, 2'd0, 3'b000, 3'b000, 3'b010}, // R6 taken
      {3'b000, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 3'b000, 3'b010, 3'b000}, // R7
      {3'b101, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 3'b001, 3'b000, 3'b000}, // R1 lowest
      {3'b000, 3'b000, 3'b000, 1'b1, 1'b0, 2'd0, 3'b000, 3'b000, 3'b000}, // R3
      {3'b000, 3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 3'b000, 3'b100, 3'b000}  // R3 R4
   };

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      // reset state, R10
      repeat (2) @(negedge clk);
      #1;
      check("R10 accept after reset", 32'(req_accept), 0);
      check("R10 retry after reset", 32'(retry), 0);
      check("R10 resp_valid after reset", 32'(resp_valid), 0);
      check("R10 mem_req_valid after reset", 32'(mem_req_valid), 0);
      check("R10 mem_hold_full after reset", 32'(mem_hold_full), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // vector walk
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         {req_valid, resp_accept, resp_retry, tgt_busy, tgt_resp_valid, tgt_resp_port} = TBL[i][21:9];
         #1;
         check($sformatf("R1/R2 row %0d req_accept", i), 32'(req_accept), 32'(TBL[i][8:6]));
         check($sformatf("R3/R4/R7 row %0d retry", i), 32'(retry), 32'(TBL[i][5:3]));
         check($sformatf("R5/R6 row %0d resp_valid", i), 32'(resp_valid), 32'(TBL[i][2:0]));
      end

      // R1: forwarded port index and payload
      @(negedge clk); idle_inputs();
      req_valid = 3'b010; req_data = {8'h00, 8'hA5, 8'h00};
      #1;
      check("R1 tgt_req_valid", 32'(tgt_req_valid), 1);
      check("R1 tgt_req_port", 32'(tgt_req_port), 1);
      check("R1 tgt_req_data", 32'(tgt_req_data), 32'hA5);

      // R5: response routed by tag
      @(negedge clk); idle_inputs();
      tgt_resp_valid = 1'b1; tgt_resp_port = 2'd2; tgt_resp_data = 8'h3C; resp_accept = 3'b100;
      #1;
      check("R5 resp_valid port 2", 32'(resp_valid), 32'b100);
      check("R5 resp_data port 2", 32'(resp_data[2*DW +: DW]), 32'h3C);

      // R6/R8: hold 5A on port 0, overflow attempt, resend keeps 5A
      @(negedge clk); idle_inputs();
      tgt_resp_valid = 1'b1; tgt_resp_port = 2'd0; tgt_resp_data = 8'h5A;
      @(negedge clk); idle_inputs();
      tgt_resp_valid = 1'b1; tgt_resp_port = 2'd0; tgt_resp_data = 8'h77;
      #1;
      check("R8 overflow on full port", 32'(overflow_err), 1);
      @(negedge clk); idle_inputs();
      #1;
      check("R8 overflow drops", 32'(overflow_err), 0);
      resp_retry = 3'b001;
      @(negedge clk); idle_inputs();
      resp_accept = 3'b001;
      #1;
      check("R6 resend valid", 32'(resp_valid), 32'b001);
      check("R8 held data kept", 32'(resp_data[DW-1:0]), 32'h5A);

      // R10: mid-run reset discards a held response
      @(negedge clk); idle_inputs();
      tgt_resp_valid = 1'b1; tgt_resp_port = 2'd1; tgt_resp_data = 8'h99;
      @(negedge clk); idle_inputs();
      req_valid = 3'b010;
      @(negedge clk); idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      req_valid = 3'b010;
      #1;
      check("R10 held and owed cleared", 32'(req_accept), 32'b010);
      @(negedge clk); idle_inputs();
      resp_retry = 3'b010;
      @(negedge clk); idle_inputs();
      #1;
      check("R10 no resend after reset", 32'(resp_valid), 0);
      check("R10 no retry after reset", 32'(retry), 0);

      // R9: memory side
      @(negedge clk); idle_inputs();
      mem_send_valid = 1'b1; mem_send_data = 8'h11; mem_req_accept = 1'b1;
      #1;
      check("R9 pass-through valid", 32'(mem_req_valid), 1);
      check("R9 pass-through data", 32'(mem_req_data), 32'h11);
      @(negedge clk); idle_inputs();
      mem_send_valid = 1'b1; mem_send_data = 8'h22;
      @(negedge clk); idle_inputs();
      #1;
      check("R9 hold full", 32'(mem_hold_full), 1);
      check("R9 nothing offered while held", 32'(mem_req_valid), 0);
      mem_send_valid = 1'b1; mem_send_data = 8'h44;
      #1;
      check("R8 mem overflow", 32'(overflow_err), 1);
      @(negedge clk); idle_inputs();
      mem_retry = 1'b1;
      @(negedge clk); idle_inputs();
      mem_req_accept = 1'b1;
      #1;
      check("R9 resend valid", 32'(mem_req_valid), 1);
      check("R9 resend data", 32'(mem_req_data), 32'h22);
      @(negedge clk); idle_inputs();
      #1;
      check("R9 emptied after accept", 32'(mem_hold_full), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule